// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block picks one of two free-running clocks, a primary and a secondary, and passes the chosen one to a single clock output. Moving from one source to the other never cuts or merges a high phase. The outgoing clock is first shut off at one of its own falling edges. Only then is the incoming clock admitted, also at one of its own falling edges. Between these two steps the output rests low.

The two clocks are unrelated, so a synchronizer clocked by each source carries the request into that source's domain. If the outgoing clock has stopped, its gate can never close by itself. A force input handles this case: it clears the stale gate asynchronously, so the handover finishes on edges of the incoming clock alone. An output enable and a power-down input act on the output directly, without any clock. When the enable is low, the output is held at a chosen constant level. Power-down holds the output low. Two status pins report whether a source is driving the output and, if so, which one.

There is no data stream, so there is no valid/ready interface. All pins are plain control, status or clock signals.

Top module: `clksel_glitchfree`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0 and `src_live` is 0. After release with `sel_sec`=0, the primary clock's first two rising edges are blocked and its third rising edge appears on `clk_out`.
- R2: When `sel_sec` changes, the old clock's next two rising edges still pass to `clk_out`. The old gate then closes at the old clock's following falling edge.
- R3: After the old gate closes, the new clock's first two rising edges are blocked and its third rising edge appears on `clk_out`.
- R4: Every high pulse on `clk_out` lasts exactly one full high phase of one source. The two gates are never open at the same time.
- R5: With the old clock stopped low and `sel_sec` already changed, raising `force_sw` lets the new clock's third rising edge after that moment reach `clk_out`.
- R6: While `force_sw` is low and the old clock is stopped, the handover does not finish: `clk_out` stays low and the status still shows the old source. Raising `force_sw` while the selection is steady does not disturb the active clock.
- R7: While `out_en` is 0 and `pwr_dn` is 0, `clk_out` equals `idle_lvl` at once, whatever the clocks are doing.
- R8: While `pwr_dn` is 1, `clk_out` is 0, whatever `out_en` and `idle_lvl` are.
- R9: `src_live` is 0 from the moment the old gate closes until the new gate opens. When `src_live` is 1, `src_sec` is 1 for the secondary source and 0 for the primary.
- R10: `out_en` and `pwr_dn` leave the selection state untouched. Once both are released, the next rising edge of the active clock appears on `clk_out` with no handover delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary source clock |
| clk_sec | input | 1 | Secondary source clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both gates |
| sel_sec | input | 1 | Source request: 0 primary, 1 secondary |
| force_sw | input | 1 | Clears the gate of the deselected source asynchronously |
| out_en | input | 1 | Output enable, asynchronous |
| idle_lvl | input | 1 | Level driven while the output is disabled |
| pwr_dn | input | 1 | Holds the output low |
| clk_out | output | 1 | Selected clock |
| src_sec | output | 1 | Active source when `src_live` is 1: 1 secondary, 0 primary |
| src_live | output | 1 | 1 while a source gate is open |

## Verification
A synchronizer stage that is stuck or missing changes the number of blocked or passed rising edges on the first switch or the first release from reset. That shows up within three cycles of the affected clock. If a gate updates on the wrong edge, or both gates are open together, `clk_out` carries a pulse whose width matches neither high phase. The pulse-width monitor reports it when that pulse falls. A faulty force path leaves the output low after `force_sw` rises, and the third secondary edge catches it.

// File: rtl/clksel_pkg.sv
`timescale 1ns/100ps
package clksel_pkg;
  typedef enum logic {SRC_PRI = 1'b0, SRC_SEC = 1'b1} src_e;
endpackage

// File: rtl/clksel_gate_chan.sv
`timescale 1ns/100ps
module clksel_gate_chan #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic want,
  output logic gate
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic                   arst_n;
  logic [SYNC_STAGES-1:0] sync_q;

  // Either reset or a forced clear empties the whole channel.
  assign arst_n = rst_n & ~clr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], want};
  end

  // The gate moves only on the falling edge, while clk is low.
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) gate <= 1'b0;
    else         gate <= sync_q[LAST];
  end

  // R2
  close_follow_chk: assert property (@(negedge clk) disable iff (!arst_n)
    !sync_q[LAST] |=> !gate);

  // R5
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (!gate && sync_q == '0));
endmodule

// File: rtl/clksel_outstage.sv
`timescale 1ns/100ps
module clksel_outstage #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] clk_vec,
  input  logic [NSRC-1:0] gate_vec,
  input  logic            out_en,
  input  logic            idle_lvl,
  input  logic            pwr_dn,
  output logic            clk_out
);
  logic gated;

  always_comb begin
    gated = 1'b0;
    for (int i = 0; i < NSRC; i++) gated = gated | (clk_vec[i] & gate_vec[i]);
  end

  always_comb begin
    if (pwr_dn)       clk_out = 1'b0;
    else if (!out_en) clk_out = idle_lvl;
    else              clk_out = gated;
  end
endmodule

// File: rtl/clksel_glitchfree.sv
`timescale 1ns/100ps
module clksel_glitchfree
  import clksel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_pri,
  input  logic clk_sec,
  input  logic rst_n,
  input  logic sel_sec,
  input  logic force_sw,
  input  logic out_en,
  input  logic idle_lvl,
  input  logic pwr_dn,
  output logic clk_out,
  output logic src_sec,
  output logic src_live
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0] clk_v;
  logic [NSRC-1:0] gate_v;
  logic [NSRC-1:0] want_v;
  logic [NSRC-1:0] clr_v;
  src_e            req;

  assign clk_v = {clk_sec, clk_pri};
  assign req   = src_e'(sel_sec);

  for (genvar g = 0; g < NSRC; g++) begin : g_chan
    // A source may open only once its partner's gate is shut.
    assign want_v[g] = (req == src_e'(g)) & ~gate_v[NSRC-1-g];
    // Forced switch clears the gate of whichever source is not requested.
    assign clr_v[g]  = force_sw & (req != src_e'(g));

    clksel_gate_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk   (clk_v[g]),
      .rst_n (rst_n),
      .clr   (clr_v[g]),
      .want  (want_v[g]),
      .gate  (gate_v[g])
    );
  end

  clksel_outstage #(.NSRC(NSRC)) u_out (
    .clk_vec  (clk_v),
    .gate_vec (gate_v),
    .out_en   (out_en),
    .idle_lvl (idle_lvl),
    .pwr_dn   (pwr_dn),
    .clk_out  (clk_out)
  );

  assign src_sec  = gate_v[SRC_SEC];
  assign src_live = |gate_v;

  // R4
  no_overlap_pri_chk: assert property (@(posedge clk_pri) disable iff (!rst_n)
    !(gate_v[SRC_PRI] && gate_v[SRC_SEC]));

  // R4
  no_overlap_sec_chk: assert property (@(posedge clk_sec) disable iff (!rst_n)
    !(gate_v[SRC_PRI] && gate_v[SRC_SEC]));

  // R3
  handoff_sec_chk: assert property (@(negedge clk_sec) disable iff (!rst_n)
    $rose(gate_v[SRC_SEC]) |-> !gate_v[SRC_PRI]);

  // R3
  handoff_pri_chk: assert property (@(negedge clk_pri) disable iff (!rst_n)
    $rose(gate_v[SRC_PRI]) |-> !gate_v[SRC_SEC]);
endmodule

// File: tb/clksel_glitchfree_bench.sv
`timescale 1ns/100ps
module clksel_glitchfree_bench;
  logic clk_pri = 1'b0, clk_sec = 1'b0;
  logic rst_n = 1'b0, sel_sec = 1'b0, force_sw = 1'b0;
  logic out_en = 1'b1, idle_lvl = 1'b0, pwr_dn = 1'b0;
  logic clk_out, src_sec, src_live;
  logic pri_run = 1'b1;
  int   n_vec = 0, n_bad = 0;
  bit   mon_en = 1'b0, rise_ok = 1'b0;
  realtime rise_t = 0.0, width_ns = 0.0;

  clksel_glitchfree u_clksel_glitchfree (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .rst_n(rst_n), .sel_sec(sel_sec),
    .force_sw(force_sw), .out_en(out_en), .idle_lvl(idle_lvl), .pwr_dn(pwr_dn),
    .clk_out(clk_out), .src_sec(src_sec), .src_live(src_live)
  );

  // Primary: 50 MHz, edges on whole ns; stops low when pri_run drops.
  initial forever begin
    #10;
    if (pri_run) clk_pri = ~clk_pri;
    else         clk_pri = 1'b0;
  end
  // Secondary: 34 ns period, edges on half ns, never coincident with primary.
  initial begin
    #3.5;
    forever begin clk_sec = 1'b1; #17; clk_sec = 1'b0; #17; end
  end

  task automatic chk(input string rq, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic wait_pos(input bit sec);
    if (sec) @(posedge clk_sec); else @(posedge clk_pri);
  endtask
  task automatic wait_neg(input bit sec);
    if (sec) @(negedge clk_sec); else @(negedge clk_pri);
  endtask

  // R4: every output pulse must be one full high phase (10 or 17 ns)
  always @(posedge clk_out) begin rise_t = $realtime; rise_ok = mon_en; end
  always @(negedge clk_out) begin
    if (mon_en && rise_ok) begin
      width_ns = $realtime - rise_t;
      n_vec++;
      if (width_ns != 10.0 && width_ns != 17.0) begin
        n_bad++;
        $display("FAIL R4: pulse width %0.1f expected 10.0 or 17.0 at %0t", width_ns, $time);
      end
    end
  end

  task automatic switch_norm(input bit to_sec, input int off);
    wait_pos(!to_sec);
    #(off);
    sel_sec = to_sec;
    for (int k = 1; k <= 2; k++) begin
      wait_pos(!to_sec); #1;
      chk("R2 old edge passes", clk_out, 1'b1);
    end
    wait_neg(!to_sec); #0.1;
    chk("R9 live low in handover", src_live, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      wait_pos(to_sec); #1;
      chk("R3 new edge gating", clk_out, k == 3);
      chk("R9 live after open", src_live, k == 3);
    end
    chk("R9 source id", src_sec, to_sec);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    int off_pri[4] = '{2, 7, 13, 18};
    int off_sec[4] = '{2, 9, 21, 30};
    // R1 reset state
    #1;
    chk("R1 out in reset", clk_out, 1'b0);
    chk("R1 live in reset", src_live, 1'b0);
    #54;
    chk("R1 out in reset late", clk_out, 1'b0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk_pri); #1;
      chk("R1 first pri edges", clk_out, k == 3);
    end
    chk("R1 live after start", src_live, 1'b1);
    chk("R1 primary active", src_sec, 1'b0);

    // R2/R3/R9 sweep of request phases in both directions
    for (int i = 0; i < 4; i++) begin
      switch_norm(1'b1, off_pri[i]);
      switch_norm(1'b0, off_sec[i]);
    end

    // R6 force with steady selection does not disturb primary
    @(posedge clk_pri); #2; force_sw = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_pri); #1;
      chk("R6 force steady", clk_out, 1'b1);
    end
    force_sw = 1'b0;

    // R6 stopped primary: switch cannot complete without force
    @(negedge clk_pri); #1; pri_run = 1'b0;
    #25; sel_sec = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_sec); #1;
      chk("R6 stuck out low", clk_out, 1'b0);
      chk("R6 status old", src_sec, 1'b0);
    end
    // R5 forced completion
    @(posedge clk_sec); #2; force_sw = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk_sec); #1;
      chk("R5 forced gating", clk_out, k == 3);
    end
    chk("R5 secondary active", src_sec, 1'b1);
    force_sw = 1'b0;
    @(negedge clk_sec); pri_run = 1'b1;
    #50;
    switch_norm(1'b0, 5);

    // R7 output disable levels
    mon_en = 1'b0;
    #3; out_en = 1'b0; idle_lvl = 1'b1; #1;
    chk("R7 idle high", clk_out, 1'b1);
    for (int k = 0; k < 5; k++) begin #7; chk("R7 idle high hold", clk_out, 1'b1); end
    idle_lvl = 1'b0; #1;
    chk("R7 idle low", clk_out, 1'b0);
    for (int k = 0; k < 5; k++) begin #7; chk("R7 idle low hold", clk_out, 1'b0); end

    // R8 power-down overrides
    pwr_dn = 1'b1; idle_lvl = 1'b1; #1;
    chk("R8 pd over idle", clk_out, 1'b0);
    out_en = 1'b1;
    for (int k = 0; k < 5; k++) begin #7; chk("R8 pd low", clk_out, 1'b0); end
    chk("R10 live kept", src_live, 1'b1);

    // R10 release resumes without handover
    pwr_dn = 1'b0;
    @(negedge clk_pri); mon_en = 1'b1;
    @(posedge clk_pri); #1;
    chk("R10 resume", clk_out, 1'b1);
    chk("R10 primary kept", src_sec, 1'b0);
    switch_norm(1'b1, 4);
    #100;
    finish_run();
  end
endmodule